// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address. It walks a radix tree of 64-bit entries held in memory. A caller supplies the effective address, an access kind (write or not), the base of the root directory, the root directory's index width, and the total size of the translated address space in bits. On a start pulse the walker takes an index out of the effective address for each level and reads one entry. Each non-leaf entry gives the next directory's base and index width. The walk continues until it meets a leaf, an invalid entry or a configuration error.

On a leaf the walker builds the real address and the page size. Leaves can appear at any level, so page sizes vary. The walker then marks the entry as referenced, and as changed on a write. It writes the entry back only if those marks alter it. The result is reported with a one-cycle done pulse and exactly one outcome flag. All memory traffic goes through a single-outstanding request port with a valid/ready handshake and a read-data-valid response.

The controller steps through these states:
- IDLE leaves for CHECK on start.
- CHECK goes to DONE on a configuration fault, otherwise to RD_REQ.
- RD_REQ goes to RD_WAIT when the read is accepted.
- RD_WAIT goes to EVAL when read data arrives.
- EVAL goes to DONE on an invalid entry, to CHECK on a non-leaf entry, to WB_REQ on a leaf whose marks changed, and to DONE on a leaf that is already marked.
- WB_REQ goes to DONE when the write is accepted.
- DONE returns to IDLE.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: busy, done, mem_valid and all outcome flags are 0.
- R2: The walk ends with flt_badcfg set in any of three cases, and it issues no further memory access: the current level's index width is below 5, MAX_LEVELS (default 4) entries have already been read without reaching a leaf, or the index width is larger than the remaining size. A root width below 5 therefore gives zero reads.
- R3: At each level the index is (effective address >> (remaining size − index width)) masked to index-width bits. The entry is read from byte address level base + 8 × index.
- R4: Entry bit 63 is the valid bit. A fetched entry with bit 63 clear ends the walk with flt_noentry.
- R5: After each level the remaining size drops by that level's index width. A valid entry with bit 62 clear is a directory entry. Its bits [PA_W-1:8] (with 8 zero low bits) give the next base, and its bits [4:0] give the next index width.
- R6: A valid entry with bit 62 set is a leaf. The real address is entry bits [PA_W-1:12] (with 12 zero low bits), with its low (remaining size) bits replaced by the effective address bits. page_shift equals the remaining size, which may be 0. xlate_ok is set.
- R7: On a leaf the updated entry always has bit 8 (reference) set. It has bit 7 (change) set only for a write access. write_allowed is 1 only when the access was a write.
- R8: The updated leaf is written back to the leaf's own address only if it differs from the fetched entry. Otherwise no write is issued.
- R9: At most one memory request is outstanding. A request holds its address, direction and data stable until mem_ready. Read data is taken in the cycle mem_rvalid is high.
- R10: done is a one-cycle pulse with exactly one of xlate_ok, flt_badcfg and flt_noentry set. Results are held until the next accepted start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| req_ea | input | EA_W | Effective address to translate |
| req_write | input | 1 | Access is a write |
| root_base | input | PA_W | Byte base of the root directory |
| root_width | input | 5 | Root index width in bits |
| space_size | input | SZ_W | Total translated size in bits |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| xlate_ok | output | 1 | Translation succeeded |
| flt_badcfg | output | 1 | Bad configuration fault |
| flt_noentry | output | 1 | Invalid entry fault |
| real_addr | output | PA_W | Translated real address |
| page_shift | output | SZ_W | log2 of the page size |
| write_allowed | output | 1 | Write permission kept in the result |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PA_W | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
Two events meet at the last allowed level. The leaf test and the level-limit test touch the same walk, and a leaf found on the fourth read must succeed while a fourth directory entry must fault. Random walks of one to four levels reach leaves at every depth, and a directed five-deep directory chain hits the limit. The read count and the outcome flag decide each case. A second meeting point is the leaf mark update and the completion: random reference and change bits on the leaf, crossed with the access kind, decide whether a write-back comes before done. That is judged by counting writes and reading the stored entry afterwards.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int ENTRY_W   = 64;
    localparam int V_BIT     = 63;
    localparam int L_BIT     = 62;
    localparam int REF_BIT   = 8;
    localparam int CHG_BIT   = 7;
    localparam int NB_LSB    = 8;
    localparam int RPN_LSB   = 12;
    localparam int WID_W     = 5;
    localparam int MIN_WIDTH = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RD_REQ,
        S_RD_WAIT,
        S_EVAL,
        S_WB_REQ,
        S_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_BADCFG,
        RES_NOENTRY
    } walk_res_e;

endpackage

// File: rtl/radix_index_calc.sv
module radix_index_calc
    import radix_walk_pkg::*;
#(
    parameter int EA_W = 64,
    parameter int PA_W = 56,
    parameter int SZ_W = 7
) (
    input  logic [EA_W-1:0]  ea,
    input  logic [PA_W-1:0]  base,
    input  logic [WID_W-1:0] width,
    input  logic [SZ_W-1:0]  remaining,
    output logic [PA_W-1:0]  entry_addr,
    output logic             cfg_bad
);

    logic [SZ_W-1:0] sh;
    logic [EA_W-1:0] mask;
    logic [EA_W-1:0] index;

    always_comb begin
        cfg_bad    = (width < WID_W'(MIN_WIDTH)) || (SZ_W'(width) > remaining);
        sh         = remaining - SZ_W'(width);
        mask       = (EA_W'(1) << width) - EA_W'(1);
        index      = (ea >> sh) & mask;
        entry_addr = base + PA_W'({index, 3'b000});
    end

endmodule

// File: rtl/radix_leaf_form.sv
module radix_leaf_form
    import radix_walk_pkg::*;
#(
    parameter int PA_W = 56,
    parameter int SZ_W = 7
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [PA_W-1:0]    ea_low,
    input  logic [SZ_W-1:0]    remaining,
    input  logic               is_write,
    output logic [PA_W-1:0]    real_addr,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               changed
);

    logic [PA_W-1:0] low_mask;
    logic [PA_W-1:0] page_base;

    always_comb begin
        low_mask  = (PA_W'(1) << remaining) - PA_W'(1);
        page_base = {entry[PA_W-1:RPN_LSB], {RPN_LSB{1'b0}}};
        real_addr = (page_base & ~low_mask) | (ea_low & low_mask);
        new_entry = entry | (ENTRY_W'(1) << REF_BIT)
                  | (is_write ? (ENTRY_W'(1) << CHG_BIT) : ENTRY_W'(0));
        changed   = (new_entry != entry);
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int EA_W       = 64,
    parameter int PA_W       = 56,
    parameter int SZ_W       = 7,
    parameter int MAX_LEVELS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [EA_W-1:0]    req_ea,
    input  logic               req_write,
    input  logic [PA_W-1:0]    root_base,
    input  logic [WID_W-1:0]   root_width,
    input  logic [SZ_W-1:0]    space_size,
    output logic               busy,
    output logic               done,
    output logic               xlate_ok,
    output logic               flt_badcfg,
    output logic               flt_noentry,
    output logic [PA_W-1:0]    real_addr,
    output logic [SZ_W-1:0]    page_shift,
    output logic               write_allowed,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata
);

    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    walk_state_e        st_q, st_d;
    walk_res_e          res_q;
    logic [EA_W-1:0]    ea_q;
    logic               wr_q;
    logic [PA_W-1:0]    base_q;
    logic [WID_W-1:0]   width_q;
    logic [SZ_W-1:0]    rem_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [PA_W-1:0]    addr_q;
    logic [PA_W-1:0]    ra_q;
    logic [SZ_W-1:0]    shift_q;
    logic               wa_q;

    logic [PA_W-1:0]    ent_addr;
    logic               cfg_bad;
    logic               lvl_full;
    logic [PA_W-1:0]    leaf_ra;
    logic [ENTRY_W-1:0] leaf_new;
    logic               leaf_dirty;

    radix_index_calc #(.EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_idx (
        .ea         (ea_q),
        .base       (base_q),
        .width      (width_q),
        .remaining  (rem_q),
        .entry_addr (ent_addr),
        .cfg_bad    (cfg_bad)
    );

    radix_leaf_form #(.PA_W(PA_W), .SZ_W(SZ_W)) u_leaf (
        .entry     (entry_q),
        .ea_low    (ea_q[PA_W-1:0]),
        .remaining (rem_q),
        .is_write  (wr_q),
        .real_addr (leaf_ra),
        .new_entry (leaf_new),
        .changed   (leaf_dirty)
    );

    assign lvl_full = (lvl_q == LVL_W'(MAX_LEVELS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:    if (start) st_d = S_CHECK;
            S_CHECK:   st_d = (cfg_bad || lvl_full) ? S_DONE : S_RD_REQ;
            S_RD_REQ:  if (mem_ready) st_d = S_RD_WAIT;
            S_RD_WAIT: if (mem_rvalid) st_d = S_EVAL;
            S_EVAL: begin
                if (!entry_q[V_BIT])      st_d = S_DONE;
                else if (!entry_q[L_BIT]) st_d = S_CHECK;
                else if (leaf_dirty)      st_d = S_WB_REQ;
                else                      st_d = S_DONE;
            end
            S_WB_REQ:  if (mem_ready) st_d = S_DONE;
            S_DONE:    st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= RES_NONE;
            ea_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            width_q <= '0;
            rem_q   <= '0;
            lvl_q   <= '0;
            entry_q <= '0;
            addr_q  <= '0;
            ra_q    <= '0;
            shift_q <= '0;
            wa_q    <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        res_q   <= RES_NONE;
                        ea_q    <= req_ea;
                        wr_q    <= req_write;
                        base_q  <= root_base;
                        width_q <= root_width;
                        rem_q   <= space_size;
                        lvl_q   <= '0;
                        ra_q    <= '0;
                        shift_q <= '0;
                        wa_q    <= 1'b0;
                    end
                end
                S_CHECK: begin
                    if (cfg_bad || lvl_full) begin
                        res_q <= RES_BADCFG;
                    end else begin
                        addr_q <= ent_addr;
                        rem_q  <= rem_q - SZ_W'(width_q);
                    end
                end
                S_RD_WAIT: begin
                    if (mem_rvalid) entry_q <= mem_rdata;
                end
                S_EVAL: begin
                    if (!entry_q[V_BIT]) begin
                        res_q <= RES_NOENTRY;
                    end else if (!entry_q[L_BIT]) begin
                        base_q  <= {entry_q[PA_W-1:NB_LSB], {NB_LSB{1'b0}}};
                        width_q <= entry_q[WID_W-1:0];
                        lvl_q   <= lvl_q + LVL_W'(1);
                    end else begin
                        ra_q    <= leaf_ra;
                        shift_q <= rem_q;
                        wa_q    <= wr_q;
                        entry_q <= leaf_new;
                        if (!leaf_dirty) res_q <= RES_OK;
                    end
                end
                S_WB_REQ: begin
                    if (mem_ready) res_q <= RES_OK;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy          = (st_q != S_IDLE);
        done          = (st_q == S_DONE);
        mem_valid     = (st_q == S_RD_REQ) || (st_q == S_WB_REQ);
        mem_we        = (st_q == S_WB_REQ);
        mem_addr      = addr_q;
        mem_wdata     = entry_q;
        xlate_ok      = (res_q == RES_OK);
        flt_badcfg    = (res_q == RES_BADCFG);
        flt_noentry   = (res_q == RES_NOENTRY);
        real_addr     = ra_q;
        page_shift    = shift_q;
        write_allowed = wa_q;
    end

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk
    import radix_walk_pkg::*;
#(
    parameter int PA_W = 56
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               xlate_ok,
    input logic               flt_badcfg,
    input logic               flt_noentry,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic               mem_we,
    input logic [PA_W-1:0]    mem_addr,
    input logic [ENTRY_W-1:0] mem_wdata
);

    logic [PA_W-1:0] last_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              last_rd_q <= '0;
        else if (mem_valid && mem_ready && !mem_we) last_rd_q <= mem_addr;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({xlate_ok, flt_badcfg, flt_noentry}) == 1);

    // R7
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[REF_BIT]);

    // R8
    wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_addr == last_rd_q);

endmodule

bind radix_walker radix_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .xlate_ok    (xlate_ok),
    .flt_badcfg  (flt_badcfg),
    .flt_noentry (flt_noentry),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EA_W = 64;
    localparam int PA_W = 56;
    localparam int SZ_W = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [EA_W-1:0] req_ea = '0;
    logic            req_write = 1'b0;
    logic [PA_W-1:0] root_base = '0;
    logic [4:0]      root_width = '0;
    logic [SZ_W-1:0] space_size = '0;
    logic            busy, done, xlate_ok, flt_badcfg, flt_noentry, write_allowed;
    logic [PA_W-1:0] real_addr;
    logic [SZ_W-1:0] page_shift;
    logic            mem_valid, mem_we;
    logic            mem_ready = 1'b0;
    logic [PA_W-1:0] mem_addr;
    logic [63:0]     mem_wdata;
    logic            mem_rvalid = 1'b0;
    logic [63:0]     mem_rdata = '0;

    logic [63:0] mem [0:1023];
    int checks = 0;
    int errs = 0;
    int n_rd = 0;
    int n_wr = 0;
    int rd_wait = 0;
    logic [9:0] rd_idx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_ea(req_ea),
        .req_write(req_write), .root_base(root_base), .root_width(root_width),
        .space_size(space_size), .busy(busy), .done(done), .xlate_ok(xlate_ok),
        .flt_badcfg(flt_badcfg), .flt_noentry(flt_noentry), .real_addr(real_addr),
        .page_shift(page_shift), .write_allowed(write_allowed),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    endtask

    // memory model: decides ready at the negedge, so the handshake is known before the edge
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rd_wait > 0) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[rd_idx];
                end
            end
            mem_ready = ($urandom_range(0, 2) != 0);
            if (mem_valid && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr[12:3]] = mem_wdata;
                    n_wr++;
                end else begin
                    rd_idx  = mem_addr[12:3];
                    rd_wait = $urandom_range(1, 3);
                    n_rd++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] idx_of(logic [63:0] ea, int rem, int w);
        return (ea >> (rem - w)) & ((64'd1 << w) - 64'd1);
    endfunction

    task automatic walk(input logic [63:0] ea, input bit wr, input int w0,
                        input int total, input bit poke);
        @(negedge clk);
        n_rd = 0;
        n_wr = 0;
        req_ea     = ea;
        req_write  = wr;
        root_base  = '0;
        root_width = 5'(w0);
        space_size = SZ_W'(total);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_ea    = ~ea;
            req_write = ~wr;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic run_rand(input int nlev, input bit wr, input bit poke);
        int w [5];
        int rem, total, psh, rc;
        logic [63:0] ea, a, leaf, leaf_a, m, ra_exp, exp_new;
        logic [19:0] rpn;
        psh   = $urandom_range(12, 20);
        total = psh;
        for (int i = 0; i < nlev; i++) begin
            w[i]  = $urandom_range(5, 6);
            total += w[i];
        end
        ea   = {$urandom, $urandom};
        rpn  = 20'($urandom);
        rc   = $urandom_range(0, 3);
        rem  = total;
        leaf = '0;
        leaf_a = '0;
        for (int i = 0; i < nlev; i++) begin
            a = 64'h400 * i + (idx_of(ea, rem, w[i]) << 3);
            rem -= w[i];
            if (i == nlev - 1) begin
                leaf = {2'b11, 62'd0} | (64'(rpn) << 12) | (64'(rc) << 7);
                mem[a[12:3]] = leaf;
                leaf_a = a;
            end else begin
                mem[a[12:3]] = {2'b10, 62'd0} | (64'h400 * (i + 1)) | 64'(w[i + 1]);
            end
        end
        walk(ea, wr, w[0], total, poke);
        m       = (64'd1 << psh) - 64'd1;
        ra_exp  = ((64'(rpn) << 12) & ~m) | (ea & m);
        exp_new = leaf | (64'd1 << 8) | (wr ? (64'd1 << 7) : 64'd0);
        chk("R6 xlate_ok", 64'(xlate_ok), 64'd1);
        chk("R10 single outcome", 64'({flt_badcfg, flt_noentry}), 64'd0);
        chk("R6 real_addr", 64'(real_addr), ra_exp);
        chk("R6 page_shift", 64'(page_shift), 64'(psh));
        chk("R7 write_allowed", 64'(write_allowed), 64'(wr));
        chk("R3 R5 read count", 64'(n_rd), 64'(nlev));
        chk("R7 stored entry", mem[leaf_a[12:3]], exp_new);
        chk("R8 write count", 64'(n_wr), (exp_new != leaf) ? 64'd1 : 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 mem_valid", 64'(mem_valid), 64'd0);
        chk("R1 flags", 64'({xlate_ok, flt_badcfg, flt_noentry}), 64'd0);

        // R2: root width below 5, no read
        walk(64'h1234, 1'b0, 4, 30, 1'b0);
        chk("R2 narrow root badcfg", 64'(flt_badcfg), 64'd1);
        chk("R2 narrow root no read", 64'(n_rd), 64'd0);

        // R4: invalid root entry
        mem[0] = 64'd0;
        walk(64'd0, 1'b0, 5, 20, 1'b0);
        chk("R4 noentry", 64'(flt_noentry), 64'd1);
        chk("R4 one read", 64'(n_rd), 64'd1);

        // R2: width larger than remaining at level 2
        mem[0] = {2'b10, 62'd0} | 64'h400 | 64'd6;
        walk(64'd0, 1'b0, 5, 8, 1'b0);
        chk("R2 width over remaining", 64'(flt_badcfg), 64'd1);
        chk("R2 stop after one read", 64'(n_rd), 64'd1);

        // R2 R5: five directory levels exceed the level limit
        begin
            logic [63:0] ea;
            int rem;
            logic [63:0] a;
            ea  = {$urandom, $urandom};
            rem = 37;
            for (int i = 0; i < 4; i++) begin
                a = 64'h400 * i + (idx_of(ea, rem, 5) << 3);
                rem -= 5;
                mem[a[12:3]] = {2'b10, 62'd0} | (64'h400 * (i + 1)) | 64'd5;
            end
            walk(ea, 1'b1, 5, 37, 1'b0);
            chk("R2 level limit badcfg", 64'(flt_badcfg), 64'd1);
            chk("R2 level limit reads", 64'(n_rd), 64'd4);
            chk("R2 level limit no write", 64'(n_wr), 64'd0);
        end

        // R6 R8: root leaf, zero page shift, already referenced and changed, write
        mem[0] = {2'b11, 62'd0} | (64'hABCDE << 12) | (64'd3 << 7);
        walk(64'd0, 1'b1, 5, 5, 1'b0);
        chk("R6 zero shift ok", 64'(xlate_ok), 64'd1);
        chk("R6 zero shift addr", 64'(real_addr), 64'hABCDE000);
        chk("R6 zero shift size", 64'(page_shift), 64'd0);
        chk("R8 clean leaf no write", 64'(n_wr), 64'd0);
        chk("R7 write keeps permission", 64'(write_allowed), 64'd1);

        // R7 R8: read of referenced, unchanged leaf
        mem[0] = {2'b11, 62'd0} | (64'h12345 << 12) | (64'd1 << 8);
        walk(64'd0, 1'b0, 5, 17, 1'b0);
        chk("R8 read clean no write", 64'(n_wr), 64'd0);
        chk("R7 read drops write", 64'(write_allowed), 64'd0);
        chk("R7 change bit untouched", mem[0], {2'b11, 62'd0} | (64'h12345 << 12) | (64'd1 << 8));

        // random walks of all depths, some with a start pulse while busy (R10)
        for (int t = 0; t < 48; t++) begin
            run_rand($urandom_range(1, 4), 1'($urandom), (t % 5) == 0);
        end
        // R10: results held until next start
        repeat (3) @(negedge clk);
        chk("R10 results held", 64'(xlate_ok), 64'd1);

        summary();
        $finish;
    end

endmodule